// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is an up-counter whose width is set by a parameter, with a preload register and three ways of advancing. In event mode it counts edges on an external pin. In timer mode it counts ticks from an internal source. In pulse-width mode it measures, once, how long the pin stays at a chosen level. When the count passes all ones, the counter reloads from the preload register. At that point the block pulses a wake-up output and, if the interrupt enable is set, raises a sticky interrupt flag.

Software controls the block through a small set of strobes. One strobe writes the enable bit. Another writes the preload. A third clears the flag. Two inputs that are normally held steady select the mode and the active edge. The internal tick comes from one of two places, picked by a configuration input. The first is a divider that runs on the block clock and divides by four by default. The second is an externally supplied real-time tick. In pulse-width mode the enable bit clears itself when the measurement ends, so software can poll it to see when the result is ready.

Top module: `multimode_timer`

## Requirements
- R1: After reset the count is 0, the preload is 0, the enable bit is 0, and the interrupt flag and wake-up output are both 0.
- R2: Timer mode is `modeSel`=2'b10. In this mode the count rises by one for each internal tick while the enable bit is set. With `srcSel`=0 the tick is the clock divided by DIV. The divider is held cleared while counting is off, so enabling for N clock cycles gives floor(N/DIV) increments.
- R3: Event mode is `modeSel`=2'b01. In this mode the count rises by one for each synchronized pin edge of the chosen polarity: rising when `edgeSel`=1, falling when `edgeSel`=0. Edges of the other polarity leave the count unchanged. The pin passes through a two-flop synchronizer.
- R4: An increment at all ones loads the count from the preload register instead. The same clock edge that does this load also produces a one-cycle pulse on `wakeup`.
- R5: An overflow sets `irqFlag` only when `irqEn` is 1. Once set, the flag stays set until a `flagClr` strobe clears it. If an overflow and a clear arrive in the same cycle, the flag ends up set.
- R6: Pulse-width mode is `modeSel`=2'b11. With the enable bit set, counting on internal ticks begins at a pin edge of the chosen polarity. Counting ends when the pin returns to its starting level, and at that point the enable bit clears itself.
- R7: After a finished measurement the count is held. Further pin pulses leave it unchanged until software writes the enable bit to 1 again. After that, the next measurement adds to the held count.
- R8: In event mode and timer mode, the enable bit stays set across overflows and is cleared only by an enable write.
- R9: A preload write while the enable bit is 0 also loads the count. A preload write while the enable bit is 1 leaves the count alone, and the new value is first used at the next overflow.
- R10: With `modeSel`=2'b00 the count never changes, whatever the enable bit, the ticks or the pin do.
- R11: With `srcSel`=1, timer mode counts one per cycle in which `rtcTick` is high, and the internal divider has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcSel | input | 1 | Internal tick source: 0 divided clock, 1 real-time tick |
| rtcTick | input | 1 | Real-time tick, one cycle wide, synchronous to clk |
| extPin | input | 1 | External event or measured signal, asynchronous |
| modeSel | input | 2 | 00 idle, 01 event, 10 timer, 11 pulse width |
| edgeSel | input | 1 | Active edge: 1 rising, 0 falling |
| enWrStb | input | 1 | Strobe that writes the enable bit |
| enWrData | input | 1 | Value written to the enable bit |
| preloadData | input | WIDTH | Preload write data |
| preloadWr | input | 1 | Preload write strobe |
| irqEn | input | 1 | Interrupt request enable |
| flagClr | input | 1 | Interrupt flag clear strobe |
| count | output | WIDTH | Live counter value |
| running | output | 1 | Current value of the enable bit |
| irqFlag | output | 1 | Sticky overflow interrupt flag |
| wakeup | output | 1 | One-cycle pulse on every overflow |

## Verification
The bench aims at the reload boundary. It starts the counter from values one or two below all ones and also from exactly all ones. A design that wrapped to zero, or that reloaded one increment late, would end with the wrong count. It also checks that a masked overflow leaves the flag low, and that a flag clear arriving in the same cycle as an overflow loses to the set. A design that reversed this priority would lose the interrupt.

In pulse-width mode the bench times a measurement to an exact tick count. It then sends a second pulse with the enable bit already cleared, which catches a design that re-arms by itself or never clears the enable bit. A preload written mid-run must not show up in the count until the next overflow, which catches a design that always copies the write into the counter. The bench also drives pin edges of the wrong polarity in event mode, and ticks in idle mode, where a design that ignored the edge or mode selection would count.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmrMode_e;

  // Strobes from control to datapath, one set per cycle.
  typedef struct packed {
    logic inc;    // advance the counter (reload at all ones)
    logic load;   // copy write data into the counter (stopped only)
    logic preWr;  // capture write data into the preload register
  } cntStrobe_t;

endpackage

// File: rtl/mtmr_datapath.sv
module mtmr_datapath
  import mtmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [WIDTH-1:0] preloadData,
  output logic [WIDTH-1:0] count,
  output logic             cntAtMax
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] preQ;
  logic [WIDTH-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ <= '0;
    end else if (strobe.preWr) begin
      preQ <= preloadData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.load) begin
      cntQ <= preloadData;
    end else if (strobe.inc) begin
      cntQ <= cntAtMax ? preQ : cntQ + WIDTH'(1);
    end
  end

  assign cntAtMax = (cntQ == ALL_ONES);
  assign count    = cntQ;

  // R4: overflow takes the value held in preload before this edge
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && cntAtMax) |=> (count == $past(preQ)));

  // R2: a non-overflow step adds exactly one
  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && !cntAtMax) |=> (count == $past(count) + WIDTH'(1)));

  // R9: a stopped-counter write lands in the count
  assert_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (count == $past(preloadData)));

  // R9: a preload write alone does not move the count
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.preWr && !strobe.load && !strobe.inc) |=> $stable(count));

endmodule

// File: rtl/mtmr_ctrl.sv
module mtmr_ctrl
  import mtmr_pkg::*;
#(
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       srcSel,
  input  logic       rtcTick,
  input  logic       extPin,
  input  logic [1:0] modeSel,
  input  logic       edgeSel,
  input  logic       enWrStb,
  input  logic       enWrData,
  input  logic       preloadWr,
  input  logic       irqEn,
  input  logic       flagClr,
  input  logic       cntAtMax,
  output cntStrobe_t strobe,
  output logic       running,
  output logic       irqFlag,
  output logic       wakeup
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

  tmrMode_e mode;
  assign mode = tmrMode_e'(modeSel);

  logic isEvent, isTimer, isPulse;
  assign isEvent = (mode == MODE_EVENT);
  assign isTimer = (mode == MODE_TIMER);
  assign isPulse = (mode == MODE_PULSE);

  // ---------------- pin synchronizer and edge detect ----------------
  logic [SYNC_STAGES-1:0] syncQ;
  logic pinLvl, pinPrev;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= extPin;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], extPin};
      end
    end
  endgenerate

  assign pinLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= pinLvl;
  end

  logic riseEdge, fallEdge, startEdge, endEdge;
  assign riseEdge  = pinLvl & ~pinPrev;
  assign fallEdge  = ~pinLvl & pinPrev;
  assign startEdge = edgeSel ? riseEdge : fallEdge;
  assign endEdge   = edgeSel ? fallEdge : riseEdge;

  // ---------------- enable bit and measurement window ----------------
  logic enQ, measQ;
  logic measDone;
  assign measDone = isPulse & measQ & endEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= 1'b0;
    end else if (enWrStb) begin
      enQ <= enWrData;
    end else if (measDone) begin
      enQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      measQ <= 1'b0;
    end else if (enWrStb || !isPulse || !enQ) begin
      measQ <= 1'b0;
    end else if (!measQ && startEdge) begin
      measQ <= 1'b1;
    end else if (measQ && endEdge) begin
      measQ <= 1'b0;
    end
  end

  // ---------------- internal tick ----------------
  logic gateOpen, divTick, tick;
  assign gateOpen = (isTimer & enQ) | measQ;

  generate
    if (DIV == 1) begin : g_nodiv
      assign divTick = gateOpen;
    end else begin : g_div
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          divCnt <= '0;
        end else if (!gateOpen || divCnt == DIV_W'(DIV - 1)) begin
          divCnt <= '0;
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
      assign divTick = gateOpen & (divCnt == DIV_W'(DIV - 1));
    end
  endgenerate

  assign tick = gateOpen & (srcSel ? rtcTick : divTick);

  // ---------------- strobes to datapath ----------------
  logic incNow, ovf;
  assign incNow = (isEvent & enQ & startEdge)
                | (isTimer & tick)
                | (isPulse & measQ & tick);
  assign ovf = incNow & cntAtMax;

  always_comb begin
    strobe       = '0;
    strobe.inc   = incNow;
    strobe.load  = preloadWr & ~enQ;
    strobe.preWr = preloadWr;
  end

  // ---------------- flag and wake-up ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
    end else if (ovf && irqEn) begin
      irqFlag <= 1'b1;
    end else if (flagClr) begin
      irqFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeup <= 1'b0;
    else       wakeup <= ovf;
  end

  assign running = enQ;

  // R6: the end of a measurement drops the enable bit
  assert_autoclr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (measDone && !enWrStb) |=> !running);

  // R8: enable falls only from a write or a finished measurement
  assert_sticky_en_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> ($past(enWrStb) || $past(measQ)));

  // R5: the flag drops only on a clear strobe
  assert_flag_clr_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqFlag) |-> $past(flagClr));

  // R5: the flag rises only while requests are enabled
  assert_flag_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(irqEn));

  // R4: a new flag always comes with a wake-up pulse
  assert_wake_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> wakeup);

  // R10: idle mode never advances the counter
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_IDLE) |-> !strobe.inc);

endmodule

// File: rtl/multimode_timer.sv
module multimode_timer
  import mtmr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcSel,
  input  logic             rtcTick,
  input  logic             extPin,
  input  logic [1:0]       modeSel,
  input  logic             edgeSel,
  input  logic             enWrStb,
  input  logic             enWrData,
  input  logic [WIDTH-1:0] preloadData,
  input  logic             preloadWr,
  input  logic             irqEn,
  input  logic             flagClr,
  output logic [WIDTH-1:0] count,
  output logic             running,
  output logic             irqFlag,
  output logic             wakeup
);

  cntStrobe_t strobe;
  logic       cntAtMax;

  mtmr_ctrl #(
    .DIV         (DIV),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .srcSel    (srcSel),
    .rtcTick   (rtcTick),
    .extPin    (extPin),
    .modeSel   (modeSel),
    .edgeSel   (edgeSel),
    .enWrStb   (enWrStb),
    .enWrData  (enWrData),
    .preloadWr (preloadWr),
    .irqEn     (irqEn),
    .flagClr   (flagClr),
    .cntAtMax  (cntAtMax),
    .strobe    (strobe),
    .running   (running),
    .irqFlag   (irqFlag),
    .wakeup    (wakeup)
  );

  mtmr_datapath #(
    .WIDTH (WIDTH)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .preloadData (preloadData),
    .count       (count),
    .cntAtMax    (cntAtMax)
  );

endmodule

// File: tb/multimode_timer_tb.sv
`timescale 1ns/1ps
module multimode_timer_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         srcSel = 1'b0, rtcTick = 1'b0, extPin = 1'b0;
  logic [1:0]   modeSel = 2'b00;
  logic         edgeSel = 1'b1, enWrStb = 1'b0, enWrData = 1'b0;
  logic [W-1:0] preloadData = '0;
  logic         preloadWr = 1'b0, irqEn = 1'b0, flagClr = 1'b0;
  logic [W-1:0] count;
  logic         running, irqFlag, wakeup;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  multimode_timer #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .rtcTick(rtcTick),
    .extPin(extPin), .modeSel(modeSel), .edgeSel(edgeSel),
    .enWrStb(enWrStb), .enWrData(enWrData), .preloadData(preloadData),
    .preloadWr(preloadWr), .irqEn(irqEn), .flagClr(flagClr),
    .count(count), .running(running), .irqFlag(irqFlag), .wakeup(wakeup)
  );

  // Timer-mode vectors: preload, enabled cycles, irqEn, expected count, expected flag
  localparam int NV = 6;
  localparam logic [W-1:0] V_PRE  [NV] = '{8'h10, 8'hFD, 8'hFE, 8'h00, 8'hFF, 8'h80};
  localparam int           V_CYC  [NV] = '{40, 20, 12, 3, 4, 100};
  localparam logic         V_IEN  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [W-1:0] V_CNT  [NV] = '{8'h1A, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h99};
  localparam logic         V_FLAG [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeEn(input logic v);
    enWrData = v; enWrStb = 1'b1;
    @(negedge clk);
    enWrStb = 1'b0;
  endtask

  task automatic writePreload(input logic [W-1:0] d);
    preloadData = d; preloadWr = 1'b1;
    @(negedge clk);
    preloadWr = 1'b0;
  endtask

  task automatic clearFlag();
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  task automatic pinPulse(input int hi, input int lo);
    extPin = edgeSel;
    repeat (hi) @(negedge clk);
    extPin = ~edgeSel;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 count", count, 0);
    check("R1 running", running, 0);
    check("R1 irqFlag", irqFlag, 0);
    check("R1 wakeup", wakeup, 0);

    // ---- vector table: timer mode, divided clock ----
    modeSel = 2'b10; srcSel = 1'b0;
    for (int i = 0; i < NV; i++) begin
      irqEn = V_IEN[i];
      clearFlag();
      writePreload(V_PRE[i]);
      check("R9 stopped load", count, V_PRE[i]);
      writeEn(1'b1);
      repeat (V_CYC[i] - 1) @(negedge clk);
      check("R8 enable held", running, 1);
      writeEn(1'b0);
      check("R2 R4 count", count, V_CNT[i]);
      check("R5 flag", irqFlag, V_FLAG[i]);
    end

    // ---- R5: set wins over simultaneous clear; R4 wake-up pulse ----
    irqEn = 1'b1;
    clearFlag();
    writePreload(8'hFF);
    writeEn(1'b1);
    repeat (3) @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    check("R5 set over clear", irqFlag, 1);
    check("R4 wakeup pulse", wakeup, 1);
    check("R4 reload", count, 8'hFF);
    @(negedge clk);
    check("R4 wakeup one cycle", wakeup, 0);
    writeEn(1'b0);
    clearFlag();
    check("R5 cleared", irqFlag, 0);

    // ---- R9: preload write while running ----
    writePreload(8'hF0);
    writeEn(1'b1);
    repeat (9) @(negedge clk);
    writePreload(8'h40);
    check("R9 running write ignored", count, 8'hF2);
    repeat (53) @(negedge clk);
    writeEn(1'b0);
    check("R9 new preload at overflow", count, 8'h40);
    check("R5 flag after overflow", irqFlag, 1);
    clearFlag();

    // ---- R11: real-time tick source ----
    srcSel = 1'b1;
    writePreload(8'h00);
    writeEn(1'b1);
    repeat (12) @(negedge clk);
    check("R11 divider unused", count, 0);
    for (int k = 0; k < 5; k++) begin
      rtcTick = 1'b1;
      @(negedge clk);
      rtcTick = 1'b0;
      repeat (2) @(negedge clk);
    end
    check("R11 rtc count", count, 5);
    writeEn(1'b0);

    // ---- R10: idle mode ----
    modeSel = 2'b00;
    writeEn(1'b1);
    for (int k = 0; k < 4; k++) begin
      rtcTick = 1'b1;
      @(negedge clk);
      rtcTick = 1'b0;
      pinPulse(3, 3);
    end
    srcSel = 1'b0;
    repeat (20) @(negedge clk);
    check("R10 idle no count", count, 5);
    writeEn(1'b0);

    // ---- R3: event mode ----
    modeSel = 2'b01; edgeSel = 1'b1; extPin = 1'b0;
    repeat (4) @(negedge clk);
    writePreload(8'h00);
    writeEn(1'b1);
    for (int k = 0; k < 3; k++) pinPulse(3, 3);
    repeat (4) @(negedge clk);
    check("R3 rising edges", count, 3);
    edgeSel = 1'b0;
    extPin = 1'b1;
    repeat (5) @(negedge clk);
    check("R3 rise ignored when falling chosen", count, 3);
    extPin = 1'b0;
    repeat (5) @(negedge clk);
    check("R3 falling edge counted", count, 4);
    extPin = 1'b1; repeat (3) @(negedge clk);
    extPin = 1'b0; repeat (5) @(negedge clk);
    check("R3 second falling edge", count, 5);
    writeEn(1'b0);

    // ---- R6 / R7: pulse-width mode ----
    modeSel = 2'b11; edgeSel = 1'b1; srcSel = 1'b0; extPin = 1'b0;
    repeat (4) @(negedge clk);
    writePreload(8'h00);
    writeEn(1'b1);
    repeat (3) @(negedge clk);
    check("R6 armed idle", count, 0);
    pinPulse(22, 6);
    check("R6 measured ticks", count, 5);
    check("R6 enable auto clear", running, 0);
    pinPulse(10, 6);
    check("R7 held after measurement", count, 5);
    check("R7 still stopped", running, 0);
    writeEn(1'b1);
    repeat (2) @(negedge clk);
    pinPulse(8, 6);
    check("R7 re-armed measurement", count, 7);
    check("R6 enable cleared again", running, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule